// File: doc/BRIEF.md
# PCI Host Bridge Register Window

This block is the processor-facing register window of a PCI host bridge. A simple CPU bus carries 32-bit word accesses (valid, write enable, byte address, write data) and gets back read data together with a ready that marks the cycle in which the access completes. Inside the window there are four groups of state:

- a 64-word local configuration header;
- a configuration address register;
- a masked memory base register;
- a masked I/O base register.

The two base values are exported to the address-decoding logic outside the block.

An indirect data port turns each CPU access into a single configuration read or write on a downstream request/response interface. The target is the address latched in the configuration address register. The CPU is stalled until the response returns.

A change of the I/O window base raises a one-cycle remap strobe, so the outside decoder can move the 256 KiB I/O window. Interrupt requests from up to 32 device/function slots are folded onto four lines, chosen by device number.

Top module: `pcib_regwin`

## Requirements
- R1: Byte offsets 0x000 to 0x0FC address 64 header words. A write stores the full word, and a read returns the stored word.
- R2: Out of reset, the header word at offset 0x004 reads 0x02900080: the command half holds only the wait-cycle bit (0x0080), and the status half holds capability-list, fast back-to-back and medium select timing (0x0290). Every other header word reads 0.
- R3: Offset 0x1C0 is the configuration address register. It resets to 0, and all 32 bits are writable and read back as written.
- R4: Offset 0x1C4 is the memory base register. It resets to 0. A write keeps bits 31:24 and bit 0 and clears the rest. `mem_base_out` always equals the register.
- R5: Offset 0x1C8 is the I/O base register. It resets to 0xFE240000, and writes are masked to bits 31:18 and bit 0. If bits 31:18 of the written value equal the current ones, the whole write is dropped, bit 0 included. Otherwise the register updates, `io_remap` is high for exactly the one cycle after the write, and `io_win_base` shows bits 31:18 with zeros below.
- R6: A write to offset 0x220 issues exactly one downstream request with `cfg_req_we`=1. The request address is the configuration address register and the data is the CPU write data.
- R7: A read of offset 0x220 issues exactly one downstream request with `cfg_req_we`=0. The CPU read data equals the `cfg_rsp_rdata` of the response.
- R8: During a data-port access, `cpu_ready` is low from the first cycle the access is presented until the cycle after `cfg_rsp_valid`. While `cfg_req_ready` is low, the request stays asserted with stable fields.
- R9: Offsets outside the listed registers, and addresses with bits 1:0 not zero, read 0. Writes to them change no register and issue no request. Such accesses complete at once.
- R10: `irq_out[k]` is the OR of `dev_irq[i]` over every device/function index i with i>>3 == k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU access present; held until completion |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Byte offset in the window |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access completes at the clock edge where this is high |
| cfg_req_valid | output | 1 | Downstream configuration request |
| cfg_req_ready | input | 1 | Downstream accepts the request |
| cfg_req_we | output | 1 | Request is a write |
| cfg_req_addr | output | 32 | Configuration address |
| cfg_req_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Response strobe |
| cfg_rsp_rdata | input | 32 | Response read data |
| mem_base_out | output | 32 | Memory base register value |
| io_win_base | output | 32 | 256 KiB-aligned I/O window base |
| io_remap | output | 1 | One-cycle pulse when the I/O window moves |
| dev_irq | input | 32 | Interrupt requests indexed by device/function |
| irq_out | output | 4 | Routed interrupt lines |

## Verification
A corrupted base or address register shows up one access later, as a wrong readback or as a wrong `cfg_req_addr` on the next data-port transfer. A masked-off bit that survives shows up at once on `mem_base_out` or `io_win_base`. A sequencer stuck outside idle never raises `cpu_ready`, which hangs the next CPU access. A sequencer that returns too early hands the CPU stale data in the same access. A missing or spurious remap strobe is visible in the single cycle after the I/O base write.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

  localparam int unsigned OFF_CFG_ADDR = 32'h1C0;
  localparam int unsigned OFF_MEM_BASE = 32'h1C4;
  localparam int unsigned OFF_IO_BASE  = 32'h1C8;
  localparam int unsigned OFF_DPORT    = 32'h220;

  localparam logic [31:0] MEMB_KEEP  = 32'hFF00_0001;
  localparam logic [31:0] IOB_KEEP   = 32'hFFFC_0001;
  localparam logic [31:0] IOB_RESET  = 32'hFE24_0000;
  localparam int          IOB_WIN_LSB = 18;

  localparam int          HDR_CMDSTAT_IDX   = 1;
  localparam logic [31:0] HDR_CMDSTAT_RESET = 32'h0290_0080;

  typedef enum logic [1:0] {PS_IDLE, PS_REQ, PS_WAIT, PS_DONE} port_state_e;

  function automatic logic [31:0] keep_memb(input logic [31:0] v);
    return v & MEMB_KEEP;
  endfunction

  function automatic logic [31:0] keep_iob(input logic [31:0] v);
    return v & IOB_KEEP;
  endfunction

  function automatic logic [31:0] iob_window(input logic [31:0] v);
    return {v[31:IOB_WIN_LSB], {IOB_WIN_LSB{1'b0}}};
  endfunction

  function automatic logic iob_moves(input logic [31:0] cur, input logic [31:0] nxt);
    return cur[31:IOB_WIN_LSB] != nxt[31:IOB_WIN_LSB];
  endfunction

  function automatic int route_line(input int devfn, input int funcs_per_dev);
    return devfn / funcs_per_dev;
  endfunction

endpackage

// File: rtl/pcib_cfg_header.sv
module pcib_cfg_header
  import pcib_pkg::*;
#(
  parameter int NWORDS = 64,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [31:0] words [NWORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++)
        words[i] <= (i == HDR_CMDSTAT_IDX) ? HDR_CMDSTAT_RESET : 32'h0;
    end else if (wr_en) begin
      words[idx] <= wdata;
    end
  end

  assign rdata = words[idx];

  // R1: a header write is visible at the same index on the next cycle
  p_hdr_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (words[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/pcib_base_regs.sv
module pcib_base_regs
  import pcib_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_addr_reg,
  input  logic        wr_mem,
  input  logic        wr_io,
  input  logic [31:0] wdata,
  output logic [31:0] cfg_addr,
  output logic [31:0] mem_base,
  output logic [31:0] io_base,
  output logic        io_remap
);

  logic io_change;
  assign io_change = wr_io && iob_moves(io_base, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr <= 32'h0;
      mem_base <= 32'h0;
      io_base  <= IOB_RESET;
      io_remap <= 1'b0;
    end else begin
      if (wr_addr_reg) cfg_addr <= wdata;
      if (wr_mem)      mem_base <= keep_memb(wdata);
      if (io_change)   io_base  <= keep_iob(wdata);
      io_remap <= io_change;
    end
  end

  // R5: the window base only moves in the cycle the remap strobe is high
  p_io_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !io_remap |-> $stable(io_base));

  // R5: a remap strobe always comes with a new upper field
  p_remap_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_remap |-> (io_base[31:IOB_WIN_LSB] != $past(io_base[31:IOB_WIN_LSB])));

  // R4: a memory base write lands masked
  p_mem_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mem |=> (mem_base == ($past(wdata) & MEMB_KEEP)));

endmodule

// File: rtl/pcib_cfg_port.sv
module pcib_cfg_port
  import pcib_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_we,
  input  logic [31:0] start_addr,
  input  logic [31:0] start_wdata,
  output logic        idle,
  output logic        done,
  output logic [31:0] rdata,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_we,
  output logic [31:0] req_addr,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_rdata
);

  port_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_IDLE;
      req_we    <= 1'b0;
      req_addr  <= 32'h0;
      req_wdata <= 32'h0;
      rdata     <= 32'h0;
    end else begin
      unique case (state)
        PS_IDLE: if (start) begin
          state     <= PS_REQ;
          req_we    <= start_we;
          req_addr  <= start_addr;
          req_wdata <= start_wdata;
        end
        PS_REQ:  if (req_ready) state <= PS_WAIT;
        PS_WAIT: if (rsp_valid) begin
          state <= PS_DONE;
          rdata <= rsp_rdata;
        end
        PS_DONE: state <= PS_IDLE;
        default: state <= PS_IDLE;
      endcase
    end
  end

  assign idle      = (state == PS_IDLE);
  assign done      = (state == PS_DONE);
  assign req_valid = (state == PS_REQ);

  // R8: a stalled request holds its fields
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_wdata)));

  // R7: completion is only signalled after a response strobe
  p_done_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rsp_valid));

endmodule

// File: rtl/pcib_irq_route.sv
module pcib_irq_route
  import pcib_pkg::*;
#(
  parameter int LINES         = 4,
  parameter int FUNCS_PER_DEV = 8,
  localparam int SLOTS        = LINES * FUNCS_PER_DEV
) (
  input  logic [SLOTS-1:0] dev_irq,
  output logic [LINES-1:0] irq_out
);

  for (genvar k = 0; k < LINES; k++) begin : g_line
    always_comb begin
      irq_out[k] = 1'b0;
      for (int i = 0; i < SLOTS; i++)
        if (route_line(i, FUNCS_PER_DEV) == k) irq_out[k] = irq_out[k] | dev_irq[i];
    end
  end

endmodule

// File: rtl/pcib_regwin.sv
module pcib_regwin
  import pcib_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int HDR_WORDS     = 64,
  parameter int IRQ_LINES     = 4,
  parameter int FUNCS_PER_DEV = 8,
  localparam int HDR_IDX_W    = $clog2(HDR_WORDS),
  localparam int HDR_BYTES    = HDR_WORDS * 4,
  localparam int SLOTS        = IRQ_LINES * FUNCS_PER_DEV
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_valid,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [31:0]          cpu_wdata,
  output logic [31:0]          cpu_rdata,
  output logic                 cpu_ready,
  output logic                 cfg_req_valid,
  input  logic                 cfg_req_ready,
  output logic                 cfg_req_we,
  output logic [31:0]          cfg_req_addr,
  output logic [31:0]          cfg_req_wdata,
  input  logic                 cfg_rsp_valid,
  input  logic [31:0]          cfg_rsp_rdata,
  output logic [31:0]          mem_base_out,
  output logic [31:0]          io_win_base,
  output logic                 io_remap,
  input  logic [SLOTS-1:0]     dev_irq,
  output logic [IRQ_LINES-1:0] irq_out
);

  logic aligned, hit_hdr, hit_areg, hit_mem, hit_io, hit_dport;
  assign aligned   = (cpu_addr[1:0] == 2'b00);
  assign hit_hdr   = aligned && (int'(cpu_addr) < HDR_BYTES);
  assign hit_areg  = (cpu_addr == ADDR_W'(OFF_CFG_ADDR));
  assign hit_mem   = (cpu_addr == ADDR_W'(OFF_MEM_BASE));
  assign hit_io    = (cpu_addr == ADDR_W'(OFF_IO_BASE));
  assign hit_dport = (cpu_addr == ADDR_W'(OFF_DPORT));

  logic wr_any;
  assign wr_any = cpu_valid && cpu_we;

  logic [31:0] hdr_rdata;
  pcib_cfg_header #(.NWORDS(HDR_WORDS)) u_hdr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_any && hit_hdr),
    .idx   (cpu_addr[HDR_IDX_W+1:2]),
    .wdata (cpu_wdata),
    .rdata (hdr_rdata)
  );

  logic [31:0] cfg_addr, mem_base, io_base;
  pcib_base_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_addr_reg (wr_any && hit_areg),
    .wr_mem      (wr_any && hit_mem),
    .wr_io       (wr_any && hit_io),
    .wdata       (cpu_wdata),
    .cfg_addr    (cfg_addr),
    .mem_base    (mem_base),
    .io_base     (io_base),
    .io_remap    (io_remap)
  );

  logic port_idle, port_done, port_start;
  logic [31:0] port_rdata;
  assign port_start = cpu_valid && hit_dport && port_idle;

  pcib_cfg_port u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (port_start),
    .start_we    (cpu_we),
    .start_addr  (cfg_addr),
    .start_wdata (cpu_wdata),
    .idle        (port_idle),
    .done        (port_done),
    .rdata       (port_rdata),
    .req_valid   (cfg_req_valid),
    .req_ready   (cfg_req_ready),
    .req_we      (cfg_req_we),
    .req_addr    (cfg_req_addr),
    .req_wdata   (cfg_req_wdata),
    .rsp_valid   (cfg_rsp_valid),
    .rsp_rdata   (cfg_rsp_rdata)
  );

  pcib_irq_route #(.LINES(IRQ_LINES), .FUNCS_PER_DEV(FUNCS_PER_DEV)) u_irq (
    .dev_irq (dev_irq),
    .irq_out (irq_out)
  );

  assign cpu_ready = hit_dport ? port_done : 1'b1;

  always_comb begin
    if (hit_hdr)        cpu_rdata = hdr_rdata;
    else if (hit_areg)  cpu_rdata = cfg_addr;
    else if (hit_mem)   cpu_rdata = mem_base;
    else if (hit_io)    cpu_rdata = io_base;
    else if (hit_dport) cpu_rdata = port_rdata;
    else                cpu_rdata = 32'h0;
  end

  assign mem_base_out = mem_base;
  assign io_win_base  = iob_window(io_base);

  // R9: no downstream request starts while the CPU addresses anything but the data port
  p_no_stray_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !hit_dport && !cfg_req_valid) |=> (!cfg_req_valid || $past(!port_idle)));

endmodule

// File: tb/pcib_regwin_tb.sv
module pcib_regwin_tb;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cpu_valid = 0, cpu_we = 0;
  logic [11:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic        cpu_ready;
  logic        cfg_req_valid, cfg_req_ready = 0, cfg_req_we;
  logic [31:0] cfg_req_addr, cfg_req_wdata;
  logic        cfg_rsp_valid = 0;
  logic [31:0] cfg_rsp_rdata = 0;
  logic [31:0] mem_base_out, io_win_base;
  logic        io_remap;
  logic [31:0] dev_irq = 0;
  logic [3:0]  irq_out;

  pcib_regwin u_dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench-side models
  logic [31:0] m_hdr [64];
  logic [31:0] m_areg, m_mbr, m_iob;
  logic [31:0] rmem [64];

  // responder record
  int          req_cnt = 0;
  int          rphase = 0, rlat = 0;
  logic        rec_we;
  logic [31:0] rec_addr, rec_wdata;

  function automatic logic [31:0] exp_mbr(input logic [31:0] v);
    return {v[31:24], 23'h0, v[0]};
  endfunction
  function automatic logic [31:0] exp_iob(input logic [31:0] v);
    return {v[31:18], 17'h0, v[0]};
  endfunction
  function automatic logic [31:0] exp_win(input logic [31:0] v);
    return {v[31:18], 18'h0};
  endfunction
  function automatic logic [3:0] exp_irq(input logic [31:0] r);
    logic [3:0] e = 0;
    for (int i = 0; i < 32; i++) if (r[i]) e[i >> 3] = 1'b1;
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cfg_rsp_valid = 0;
    cfg_req_ready = 0;
    if (!rst_n) rphase = 0;
    else if (rphase == 0) begin
      if (cfg_req_valid && ($urandom % 2 == 0)) begin
        cfg_req_ready = 1;
        rec_we = cfg_req_we; rec_addr = cfg_req_addr; rec_wdata = cfg_req_wdata;
        req_cnt++;
        rlat = $urandom % 4;
        rphase = 1;
      end
    end else if (rlat == 0) begin
      cfg_rsp_valid = 1;
      cfg_rsp_rdata = rec_we ? 32'hDEAD_0000 : rmem[rec_addr[7:2]];
      if (rec_we) rmem[rec_addr[7:2]] = rec_wdata;
      rphase = 0;
    end else rlat--;
  end

  task automatic xfer(input logic we, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic rdy_first);
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1 rdy_first = cpu_ready;
    while (!cpu_ready) begin @(negedge clk); #1; end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_valid = 0; cpu_we = 0;
  endtask

  task automatic io_write(input logic [31:0] d);
    logic [31:0] rd; logic rf; logic moves;
    moves = (d[31:18] != m_iob[31:18]);
    xfer(1, 12'h1C8, d, rd, rf);
    chk("R5 remap strobe", {31'h0, io_remap}, {31'h0, moves});
    if (moves) m_iob = exp_iob(d);
    chk("R5 window base", io_win_base, exp_win(m_iob));
    xfer(0, 12'h1C8, 0, rd, rf);
    chk("R5 readback", rd, m_iob);
    chk("R5 strobe single", {31'h0, io_remap}, 32'h0);
  endtask

  task automatic dport(input logic we);
    logic [31:0] rd, d, e; logic rf; int c0;
    d = $urandom; c0 = req_cnt;
    e = rmem[m_areg[7:2]];
    xfer(we, 12'h220, d, rd, rf);
    chk("R8 stall at start", {31'h0, rf}, 32'h0);
    chk("R8 one request", req_cnt, c0 + 1);
    chk(we ? "R6 req addr" : "R7 req addr", rec_addr, m_areg);
    chk(we ? "R6 req we" : "R7 req we", {31'h0, rec_we}, {31'h0, we});
    if (we) chk("R6 req data", rec_wdata, d);
    else    chk("R7 read data", rd, e);
  endtask

  task automatic undef_access();
    logic [31:0] rd; logic rf; logic [11:0] a; int c0;
    case ($urandom % 7)
      0: a = 12'h100; 1: a = 12'h1CC; 2: a = 12'h200; 3: a = 12'h21C;
      4: a = 12'h224; 5: a = 12'hFFC; default: a = 12'h1C1;
    endcase
    c0 = req_cnt;
    xfer(1, a, $urandom, rd, rf);
    chk("R9 write completes", {31'h0, rf}, 32'h1);
    chk("R9 no remap", {31'h0, io_remap}, 32'h0);
    xfer(0, a, 0, rd, rf);
    chk("R9 reads zero", rd, 32'h0);
    chk("R9 no request", req_cnt, c0);
    xfer(0, 12'h1C0, 0, rd, rf); chk("R9 areg kept", rd, m_areg);
    xfer(0, 12'h1C4, 0, rd, rf); chk("R9 mbr kept", rd, m_mbr);
    xfer(0, 12'h1C8, 0, rd, rf); chk("R9 iob kept", rd, m_iob);
  endtask

  initial begin
    logic [31:0] rd, d; logic rf; int idx;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      m_hdr[i] = (i == 1) ? 32'h0290_0080 : 32'h0;
      rmem[i]  = 32'hC0F1_0000 ^ (i * 32'h0101_0307);
    end
    m_areg = 0; m_mbr = 0; m_iob = 32'hFE24_0000;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    chk("R5 reset window", io_win_base, 32'hFE24_0000);
    chk("R4 reset export", mem_base_out, 32'h0);
    chk("R8 no request at reset", {31'h0, cfg_req_valid}, 32'h0);
    for (int i = 0; i < 64; i++) begin
      xfer(0, 12'(i * 4), 0, rd, rf);
      chk("R2 header reset", rd, m_hdr[i]);
    end
    xfer(0, 12'h1C0, 0, rd, rf); chk("R3 reset", rd, 32'h0);
    xfer(0, 12'h1C4, 0, rd, rf); chk("R4 reset", rd, 32'h0);
    xfer(0, 12'h1C8, 0, rd, rf); chk("R5 reset", rd, 32'hFE24_0000);

    // directed corners
    xfer(1, 12'h0FC, 32'hA5A5_5A5A, rd, rf); m_hdr[63] = 32'hA5A5_5A5A;
    xfer(1, 12'h000, 32'h1234_5678, rd, rf); m_hdr[0] = 32'h1234_5678;
    xfer(0, 12'h0FC, 0, rd, rf); chk("R1 last word", rd, 32'hA5A5_5A5A);
    xfer(0, 12'h000, 0, rd, rf); chk("R1 first word", rd, 32'h1234_5678);
    io_write(32'hFE27_FFFF);          // same upper bits: dropped, bit 0 too
    io_write(32'h0004_0001);          // moves
    io_write(32'h0007_0000);          // same upper: keeps bit 0
    xfer(1, 12'h1C4, 32'hFFFF_FFFF, rd, rf); m_mbr = exp_mbr(32'hFFFF_FFFF);
    chk("R4 mask export", mem_base_out, 32'hFF00_0001);
    xfer(1, 12'h1C0, 32'h8000_0010, rd, rf); m_areg = 32'h8000_0010;
    dport(1); dport(0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 8)
        0: begin idx = $urandom % 64; d = $urandom;
             xfer(1, 12'(idx * 4), d, rd, rf); m_hdr[idx] = d; end
        1: begin idx = $urandom % 64;
             xfer(0, 12'(idx * 4), 0, rd, rf); chk("R1 header read", rd, m_hdr[idx]); end
        2: begin d = $urandom; xfer(1, 12'h1C0, d, rd, rf); m_areg = d;
             xfer(0, 12'h1C0, 0, rd, rf); chk("R3 readback", rd, m_areg); end
        3: begin d = $urandom; xfer(1, 12'h1C4, d, rd, rf); m_mbr = exp_mbr(d);
             chk("R4 export", mem_base_out, m_mbr);
             xfer(0, 12'h1C4, 0, rd, rf); chk("R4 readback", rd, m_mbr); end
        4: begin d = $urandom;
             if ($urandom % 2) d[31:18] = m_iob[31:18];
             io_write(d); end
        5: dport($urandom % 2);
        6: undef_access();
        default: begin
             @(negedge clk); dev_irq = $urandom;
             if ($urandom % 3 == 0) dev_irq = 32'h1 << ($urandom % 32);
             #1 chk("R10 routing", {28'h0, irq_out}, {28'h0, exp_irq(dev_irq)}); end
      endcase
    end
    @(negedge clk); dev_irq = 0;
    #1 chk("R10 quiet", {28'h0, irq_out}, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule